// File: doc/BRIEF.md
# Monochrome Framebuffer Pixel Scanner

This block holds a one-bit-per-pixel picture in a word-organised buffer and streams it out pixel by pixel in raster order. A processor-side port reads and writes whole 16-pixel words with the same timing as ordinary data memory: the read value follows the address within the cycle, and a write takes effect at the clock edge. Independently of that port, a scan engine walks the picture left to right along each row and top to bottom through the rows, and delivers one pixel per transfer together with its row and column numbers and a frame-start flag.

Each word packs 16 horizontally adjacent pixels, the leftmost in bit 0. Row r begins at word r times (COLS/16), so a full 256 by 512 display uses 32 words per row and 8192 words in all (ROWS=256). The defaults elaborate a 64-row slice of that display. A pixel value of 1 means black and 0 means white. The scan output is a valid/ready stream. The consumer may hold ready low for any number of cycles; the offered pixel, its coordinates and its flag then stay frozen until a transfer takes place. The scan engine fetches the next word while the current one is still being shifted out, so with ready held high a pixel leaves on every cycle, across word and row boundaries alike.

Top module: `fb_scanout`

## Requirements
- R1: Accepted pixels follow raster order: the column steps from 0 to COLS-1 inside a row, then the row steps by one; after pixel (ROWS-1, COLS-1) the scan returns to (0, 0) and repeats without end.
- R2: The pixel offered at row r, column c equals bit (c mod 16) of buffer word r*(COLS/16) + c/16, with bit 0 the least significant bit and the leftmost pixel of the word.
- R3: cpu_rdata shows the buffer word at cpu_addr within the same cycle, with no clock edge between a change of address and the new data.
- R4: With cpu_we high at a rising clock edge, cpu_wdata is stored at cpu_addr at that edge; before the edge cpu_rdata still shows the old word, afterwards the new one.
- R5: pix_sof is high exactly while pixel (0, 0) is offered, so it rises on the pixel following each accepted (ROWS-1, COLS-1).
- R6: During reset pix_valid and pix_sof are low; pix_valid stays low on the first clock edge after reset is released and goes high on the second, offering pixel (0, 0). A pixel transfers on an edge where pix_valid and pix_ready are both high; while pix_valid is high and pix_ready low, pix_data, pix_row, pix_col and pix_sof do not change.
- R7: Once high, pix_valid remains high until the next reset, so with pix_ready held high one pixel transfers on every cycle, including at word and row boundaries.
- R8: A word written through the processor port at a clock edge at least two cycles before pixel (0, 0) of a frame is first offered appears with its new value in every pixel of that frame.
- R9: Reset (rst, synchronous, active high) returns the scan to pixel (0, 0) and leaves the buffer contents untouched; processor writes are accepted while reset is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports and the scan engine |
| rst | input | 1 | Synchronous active-high reset of the scan engine |
| cpu_addr | input | clog2(ROWS*COLS/16) (11) | Word address for processor reads and writes |
| cpu_we | input | 1 | Write enable, acted on at the rising edge |
| cpu_wdata | input | 16 | Word to store |
| cpu_rdata | output | 16 | Word at cpu_addr, combinational |
| pix_valid | output | 1 | A pixel is being offered |
| pix_ready | input | 1 | Consumer accepts the offered pixel at this edge |
| pix_data | output | 1 | Offered pixel, 1 black, 0 white |
| pix_row | output | clog2(ROWS) (6) | Row of the offered pixel |
| pix_col | output | clog2(COLS) (9) | Column of the offered pixel |
| pix_sof | output | 1 | Offered pixel is the first of a frame |

## Verification
The bench builds the block with ROWS=8 and COLS=48, giving three words per row and a 24-word buffer whose word count is not a power of two, so the wrap of the fetch address from the last word back to word 0 is exercised rather than falling out of a natural counter overflow. A frame is then only 384 pixels, which brings many complete frames, row and frame wraps under both continuous and randomly throttled acceptance, processor writes racing the scan, and a reset in mid-frame within a short run.

// File: rtl/fb_pkg.sv
package fb_pkg;

  // Horizontal pixels carried by one buffer word
  localparam int unsigned PIX_PER_WORD = 16;

  // Start-up sequence of the word staging logic
  typedef enum logic [1:0] {
    FILL_IDLE  = 2'd0,
    FILL_PRIME = 2'd1,
    FILL_RUN   = 2'd2
  } fill_state_e;

endpackage

// File: rtl/fb_store.sv
module fb_store #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 2048,
  parameter int AW     = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     cpu_addr,
  input  logic              cpu_we,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  input  logic [AW-1:0]     scan_addr,
  output logic [WORD_W-1:0] scan_word
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (cpu_we) mem[cpu_addr] <= cpu_wdata;
  end

  // Scan side: registered read, refreshed every cycle
  always_ff @(posedge clk) begin
    scan_word <= mem[scan_addr];
  end

  assign cpu_rdata = mem[cpu_addr];

  // R4
  wr_visible_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_we) && !$past(rst) && cpu_addr == $past(cpu_addr)) |-> cpu_rdata == $past(cpu_wdata));

endmodule

// File: rtl/fb_scan_pos.sv
module fb_scan_pos #(
  parameter int ROWS = 64,
  parameter int COLS = 512,
  parameter int RW   = 6,
  parameter int CW   = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [RW-1:0] row,
  output logic [CW-1:0] col
);

  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

  logic col_end, row_end;
  assign col_end = (col == COL_LAST);
  assign row_end = (row == ROW_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      row <= '0;
      col <= '0;
    end else if (adv) begin
      if (col_end) begin
        col <= '0;
        row <= row_end ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  // R1
  col_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && col != COL_LAST) |=> (col == $past(col) + 1'b1) && $stable(row));

  // R1
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && col == COL_LAST) |=> col == '0 &&
      row == (($past(row) == ROW_LAST) ? '0 : $past(row) + 1'b1));

  // R6
  pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(row) && $stable(col));

endmodule

// File: rtl/fb_word_pipe.sv
module fb_word_pipe
  import fb_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WPR    = 32,
  parameter int DEPTH  = 2048,
  parameter int AW     = 11,
  parameter int RW     = 6,
  parameter int CW     = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [RW-1:0]     row,
  input  logic [CW-1:0]     col,
  input  logic [WORD_W-1:0] scan_word,
  output logic [AW-1:0]     scan_addr,
  output logic              valid,
  output logic              pixel
);

  localparam int BW = $clog2(WORD_W);
  localparam logic [AW-1:0] IDX_LAST = AW'(DEPTH - 1);

  fill_state_e       st;
  logic [WORD_W-1:0] cur_word;
  logic [AW-1:0]     cur_idx, nxt_idx;
  logic              word_end;

  assign cur_idx  = AW'(int'(row) * WPR + int'(col[CW-1:BW]));
  assign nxt_idx  = (cur_idx == IDX_LAST) ? '0 : cur_idx + 1'b1;
  assign word_end = &col[BW-1:0];

  // Before running, fetch the word under the scan position; afterwards the following one
  assign scan_addr = (st == FILL_RUN) ? nxt_idx : cur_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= FILL_IDLE;
    end else begin
      unique case (st)
        FILL_IDLE:  st <= FILL_PRIME;
        FILL_PRIME: st <= FILL_RUN;
        default:    st <= FILL_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == FILL_PRIME) begin
      cur_word <= scan_word;
    end else if (st == FILL_RUN && adv && word_end) begin
      cur_word <= scan_word;
    end
  end

  assign valid = (st == FILL_RUN);
  assign pixel = cur_word[col[BW-1:0]];

  // R7
  valid_keep_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> valid);

endmodule

// File: rtl/fb_scanout.sv
module fb_scanout #(
  parameter int ROWS   = 64,
  parameter int COLS   = 512,
  parameter int WORD_W = fb_pkg::PIX_PER_WORD,
  localparam int WPR   = COLS / WORD_W,
  localparam int DEPTH = ROWS * WPR,
  localparam int AW    = $clog2(DEPTH),
  localparam int RW    = $clog2(ROWS),
  localparam int CW    = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     cpu_addr,
  input  logic              cpu_we,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic              pix_data,
  output logic [RW-1:0]     pix_row,
  output logic [CW-1:0]     pix_col,
  output logic              pix_sof
);

  logic [AW-1:0]     scan_addr;
  logic [WORD_W-1:0] scan_word;
  logic              adv;

  assign adv = pix_valid && pix_ready;

  fb_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_we    (cpu_we),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .scan_addr (scan_addr),
    .scan_word (scan_word)
  );

  fb_scan_pos #(.ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)) u_pos (
    .clk (clk),
    .rst (rst),
    .adv (adv),
    .row (pix_row),
    .col (pix_col)
  );

  fb_word_pipe #(.WORD_W(WORD_W), .WPR(WPR), .DEPTH(DEPTH), .AW(AW), .RW(RW), .CW(CW)) u_pipe (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .row       (pix_row),
    .col       (pix_col),
    .scan_word (scan_word),
    .scan_addr (scan_addr),
    .valid     (pix_valid),
    .pixel     (pix_data)
  );

  assign pix_sof = pix_valid && (pix_row == '0) && (pix_col == '0);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !pix_ready) |=> pix_valid && $stable(pix_data) &&
      $stable(pix_row) && $stable(pix_col) && $stable(pix_sof));

  // R5
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && pix_col == CW'(COLS - 1) && pix_row == RW'(ROWS - 1)) |=> pix_sof);

  // R5
  sof_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && pix_sof) |=> !pix_sof);

endmodule

// File: tb/fb_scanout_bench.sv
`timescale 1ns/1ps
module fb_scanout_bench;

  localparam int ROWS   = 8;
  localparam int COLS   = 48;
  localparam int WORD_W = 16;
  localparam int WPR    = COLS / WORD_W;
  localparam int DEPTH  = ROWS * WPR;
  localparam int AW     = $clog2(DEPTH);
  localparam int RW     = $clog2(ROWS);
  localparam int CW     = $clog2(COLS);
  localparam int FRAME  = ROWS * COLS;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [AW-1:0]     cpu_addr = '0;
  logic              cpu_we = 1'b0;
  logic [WORD_W-1:0] cpu_wdata = '0;
  logic [WORD_W-1:0] cpu_rdata;
  logic              pix_valid, pix_ready, pix_data, pix_sof;
  logic [RW-1:0]     pix_row;
  logic [CW-1:0]     pix_col;

  always #4 clk = ~clk;

  fb_scanout #(.ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W)) u_fb_scanout (
    .clk (clk), .rst (rst),
    .cpu_addr (cpu_addr), .cpu_we (cpu_we), .cpu_wdata (cpu_wdata), .cpu_rdata (cpu_rdata),
    .pix_valid (pix_valid), .pix_ready (pix_ready), .pix_data (pix_data),
    .pix_row (pix_row), .pix_col (pix_col), .pix_sof (pix_sof)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [WORD_W-1:0] mem_m [DEPTH];
  int                wr_edge [DEPTH];
  bit                wr_scan [DEPTH];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Scan monitor: samples 1 ns after the falling edge, after the drivers
  bit   mon_on = 0;
  bit   have_prev = 0;
  logic pv_valid, pv_ready, pv_data, pv_sof;
  int   pv_row, pv_col;
  int   er = 0, ec = 0;
  int   fs_edge = -1000;
  int   frames = 0;

  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      if (have_prev && pv_valid) begin
        chk(pix_valid, "R7 valid stays high", pix_valid, 1);
        if (!pv_ready)
          chk(pix_data == pv_data && int'(pix_row) == pv_row && int'(pix_col) == pv_col &&
              pix_sof == pv_sof, "R6 stalled pixel held",
              {pix_row, pix_col, pix_data}, {pv_row[RW-1:0], pv_col[CW-1:0], pv_data});
      end
      if (pix_valid) begin
        if (!(have_prev && pv_valid && !pv_ready)) begin
          int w;
          chk(int'(pix_row) == er && int'(pix_col) == ec, "R1 raster position",
              {pix_row, pix_col}, {er[RW-1:0], ec[CW-1:0]});
          chk(pix_sof == (er == 0 && ec == 0), "R5 frame start flag", pix_sof, (er == 0 && ec == 0));
          if (er == 0 && ec == 0) fs_edge = cyc;
          w = er * WPR + ec / WORD_W;
          if (wr_edge[w] + 2 <= fs_edge) begin
            if (wr_scan[w])
              chk(pix_data == mem_m[w][ec % WORD_W], "R8 written word shown next frame",
                  pix_data, mem_m[w][ec % WORD_W]);
            else
              chk(pix_data == mem_m[w][ec % WORD_W], "R2 pixel address formula",
                  pix_data, mem_m[w][ec % WORD_W]);
          end
        end
        if (pix_ready) begin
          if (ec == COLS - 1) begin
            ec = 0;
            if (er == ROWS - 1) begin
              er = 0;
              frames++;
            end else er++;
          end else ec++;
        end
      end
      pv_valid = pix_valid; pv_ready = pix_ready; pv_data = pix_data; pv_sof = pix_sof;
      pv_row = int'(pix_row); pv_col = int'(pix_col);
      have_prev = 1;
    end else begin
      have_prev = 0;
    end
  end

  task automatic cpu_write(input int a, input logic [WORD_W-1:0] d, input bit chk_old);
    @(negedge clk);
    cpu_addr = AW'(a); cpu_wdata = d; cpu_we = 1'b1;
    wr_edge[a] = cyc + 1;
    #1;
    if (chk_old) chk(cpu_rdata == mem_m[a], "R4 old word until the edge", cpu_rdata, mem_m[a]);
    @(posedge clk);
    mem_m[a] = d;
    #1 cpu_we = 1'b0;
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      cpu_addr = AW'(a);
      #1 chk(cpu_rdata == mem_m[a], tag, cpu_rdata, mem_m[a]);
    end
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    bit pend;
    int pa;
    logic [WORD_W-1:0] pd;
    void'($urandom(32'd2024));
    pix_ready = 1'b0;
    for (int a = 0; a < DEPTH; a++) begin
      wr_edge[a] = -1000; wr_scan[a] = 0; mem_m[a] = '0;
    end

    repeat (3) @(negedge clk);
    #1 chk(!pix_valid && !pix_sof, "R6 idle during reset", {pix_valid, pix_sof}, 0);

    // R3 / R4 directed: second write sees the first until its edge, then the new word
    cpu_write(3, 16'h1111, 0);
    cpu_write(3, 16'hA5A5, 1);
    @(negedge clk); cpu_addr = AW'(3);
    #1 chk(cpu_rdata == 16'hA5A5, "R4 new word after the edge", cpu_rdata, 16'hA5A5);

    // Fill: directed corners then random words, all while reset is held (R9)
    cpu_write(0, 16'h0001, 0);
    cpu_write(1, 16'h8000, 0);
    cpu_write(2, 16'hFFFF, 0);
    cpu_write(3, 16'h0000, 0);
    cpu_write(4, 16'h5555, 0);
    for (int a = 5; a < DEPTH; a++) cpu_write(a, WORD_W'($urandom), 0);
    read_all("R3 combinational read");

    // Release reset: valid after exactly two edges at pixel (0,0)
    @(negedge clk); rst = 1'b0; mon_on = 1; er = 0; ec = 0;
    @(negedge clk);
    #1 chk(!pix_valid, "R6 no pixel one edge after reset", pix_valid, 0);
    @(negedge clk);
    #1 chk(pix_valid && pix_sof && pix_row == '0 && pix_col == '0, "R6 first pixel two edges after reset",
           {pix_valid, pix_sof, pix_row, pix_col}, {2'b11, RW'(0), CW'(0)});

    // Continuous acceptance: two full frames with no gaps (R7)
    pix_ready = 1'b1;
    repeat (2 * FRAME + 7) @(negedge clk);

    // Throttled acceptance
    for (int i = 0; i < 2 * FRAME; i++) begin
      @(negedge clk);
      pix_ready = ($urandom % 4) != 0;
    end
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      pix_ready = ($urandom % 5) == 0;
    end

    // Processor writes racing the scan (R8)
    pend = 0;
    for (int i = 0; i < 3 * FRAME; i++) begin
      @(negedge clk);
      if (pend) begin mem_m[pa] = pd; pend = 0; end
      cpu_we = 1'b0;
      pix_ready = ($urandom % 3) != 0;
      if ($urandom % 6 == 0) begin
        pa = int'($urandom % DEPTH);
        pd = WORD_W'($urandom);
        cpu_addr = AW'(pa); cpu_wdata = pd; cpu_we = 1'b1;
        wr_edge[pa] = cyc + 1; wr_scan[pa] = 1; pend = 1;
      end
    end
    @(negedge clk);
    if (pend) begin mem_m[pa] = pd; pend = 0; end
    cpu_we = 1'b0;
    pix_ready = 1'b1;
    repeat (2 * FRAME + 5) @(negedge clk);
    chk(frames >= 7, "R1 frames completed", frames, 7);

    // Reset in mid-frame: buffer kept, scan restarts at (0,0) (R9)
    repeat (57) @(negedge clk);
    rst = 1'b1; mon_on = 0; pix_ready = 1'b0;
    repeat (2) @(negedge clk);
    read_all("R9 buffer kept through reset");
    @(negedge clk); rst = 1'b0; er = 0; ec = 0; mon_on = 1;
    repeat (2) @(negedge clk);
    #1 chk(pix_valid && pix_sof && pix_row == '0 && pix_col == '0, "R9 scan restarts at origin",
           {pix_valid, pix_sof, pix_row, pix_col}, {2'b11, RW'(0), CW'(0)});
    pix_ready = 1'b1;
    repeat (FRAME + 5) @(negedge clk);
    finish_run();
  end

endmodule